// File: doc/BRIEF.md
# Frequency Lock Detector with Loop Selection

This block decides whether a clock recovery loop should be steered by its phase-frequency detector or by its bang-bang phase detector. It counts edges of the recovered clock, after that clock has been divided down to the parallel-word rate, and edges of a reference clock. Both counts are taken over the same measurement window, and the block compares the recovered count with the count a correctly tuned oscillator would give.

When the two counts disagree by more than the selected tolerance, the block drops `lock_o` and hands the loop to the frequency detector. When they agree, it raises `lock_o` and selects the bang-bang detector. A hysteresis rule keeps the outputs from chattering. The recovered count crosses into the reference domain as a Gray code. A reference-rate select lets the same expected count be used whether the reference runs at the word rate or at a quarter of it.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst_ni` is low, and after its release until a lock decision is made, `lock_o` is 0 and `mode_o` is 0 (frequency detector). Asserting `rst_ni` low clears both at once, without waiting for a clock.
- R2: With `rate_sel_i`=0 the window lasts 2^WIN_LOG2 reference cycles, and with `rate_sel_i`=1 it lasts 2^(WIN_LOG2-2) reference cycles. In both cases the expected recovered count per window is 2^WIN_LOG2, so a recovered clock at the wrong ratio for the selected rate is reported out of range.
- R3: With `range_sel_i`=0 a window is in range when |recovered count − 2^WIN_LOG2| ≤ TOL_NARROW (default 8).
- R4: With `range_sel_i`=1 a window is in range when the same absolute difference is ≤ TOL_WIDE (default 32).
- R5: A single out-of-range window clears `lock_o` and sets `mode_o` to 0 at the end of that window.
- R6: `lock_o` rises, and `mode_o` becomes 1 (bang-bang detector), only at the end of the second of two consecutive in-range windows. The first window after reset only captures a starting count and is never judged.
- R7: `mode_o` changes only at a window boundary, and outside reset it equals `lock_o` (1 = bang-bang, 0 = frequency detector).
- R8: A change of `range_sel_i` or `rate_sel_i` restarts the current window and throws away its partial count. If the selects keep changing faster than one window, no window completes and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all decision logic runs on it |
| rec_clk_i | input | 1 | Recovered clock divided to the parallel-word rate |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| range_sel_i | input | 1 | Tolerance select: 0 narrow, 1 wide |
| rate_sel_i | input | 1 | Reference-rate select: 0 word rate, 1 quarter rate |
| lock_o | output | 1 | Frequency lock indication |
| mode_o | output | 1 | Loop detector select: 0 frequency detector, 1 bang-bang |

## Verification
The recovered clock period is set so that each window counts a chosen offset from the ideal count. Offsets of 0 and ±4 lie inside both tolerances. Offsets of ±20 lie between the two tolerances and show whether the range select is honoured. Offsets of ±60 lie outside both, and offsets drawn at random keep a margin from each threshold. Under the quarter-rate reference, a matching clock and a clock left at word-rate frequency separate correct window scaling from a fixed window length. Reset-aligned runs show whether locking takes two windows or one and whether one bad window is enough to unlock. Toggling the range select every fraction of a window shows whether a partial window is discarded or evaluated.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  typedef enum logic {
    MODE_FREQ = 1'b0,
    MODE_BANG = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/fld_gray_xfer.sv
`timescale 1ns/1ps
// Free-running recovered-clock counter, moved to the reference domain in Gray code.
module fld_gray_xfer #(
  parameter int CW = 17
) (
  input  logic          rec_clk_i,
  input  logic          ref_clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] bin_q, bin_nxt, gray_q;
  logic [CW-1:0] sync1_q, sync2_q;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = CW - 1; i >= 0; i--) begin
      acc      = acc ^ sync2_q[i];
      cnt_o[i] = acc;
    end
  end
endmodule

// File: rtl/fld_window_timer.sv
`timescale 1ns/1ps
// Window boundary generator; restarts when a select input changes.
module fld_window_timer #(
  parameter int WIN_LOG2 = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                range_sel_i,
  input  logic                rate_sel_i,
  output logic                tick_o,
  output logic                restart_o,
  output logic                range_o,
  output logic [WIN_LOG2-1:0] timer_o
);
  localparam int TW = WIN_LOG2;
  localparam logic [TW-1:0] LAST_FULL    = '1;
  localparam logic [TW-1:0] LAST_QUARTER = TW'((2 ** (WIN_LOG2 - 2)) - 1);

  logic          range_q, rate_q;
  logic [TW-1:0] timer_q, last;

  assign restart_o = (range_sel_i != range_q) || (rate_sel_i != rate_q);
  assign last      = rate_q ? LAST_QUARTER : LAST_FULL;
  assign tick_o    = !restart_o && (timer_q == last);
  assign range_o   = range_q;
  assign timer_o   = timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q <= 1'b0;
      rate_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      range_q <= range_sel_i;
      rate_q  <= rate_sel_i;
      if (restart_o || timer_q == last) timer_q <= '0;
      else                              timer_q <= timer_q + 1'b1;
    end
  end
endmodule

// File: rtl/fld_lock_fsm.sv
`timescale 1ns/1ps
// Per-window count compare, two-window lock qualification, one-window unlock.
module fld_lock_fsm
  import fld_pkg::*;
#(
  parameter int CW         = 17,
  parameter int WIN_LOG2   = 14,
  parameter int TOL_NARROW = 8,
  parameter int TOL_WIDE   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          range_i,
  input  logic [CW-1:0] cnt_i,
  output logic          lock_o,
  output loop_mode_e    mode_o,
  output logic          eval_valid_o,
  output logic          eval_ok_o
);
  localparam int CW1 = CW + 1;
  localparam logic [CW:0] EXP_CNT = CW1'(2 ** WIN_LOG2);
  localparam logic [CW:0] TOL_N   = CW1'(TOL_NARROW);
  localparam logic [CW:0] TOL_W   = CW1'(TOL_WIDE);

  logic [CW-1:0] snap_q, diff;
  logic [CW:0]   dev, mag, tol;
  logic          armed_q, good_q, lock_q;
  loop_mode_e    mode_q;

  assign diff = cnt_i - snap_q;
  assign dev  = {1'b0, diff} - EXP_CNT;
  assign mag  = dev[CW] ? (~dev + 1'b1) : dev;
  assign tol  = range_i ? TOL_W : TOL_N;

  assign eval_ok_o    = (mag <= tol);
  assign eval_valid_o = tick_i && armed_q && !restart_i;
  assign lock_o       = lock_q;
  assign mode_o       = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
      good_q  <= 1'b0;
      lock_q  <= 1'b0;
      mode_q  <= MODE_FREQ;
    end else if (restart_i) begin
      snap_q <= cnt_i;
    end else if (tick_i) begin
      snap_q  <= cnt_i;
      armed_q <= 1'b1;
      if (armed_q) begin
        if (eval_ok_o) begin
          good_q <= 1'b1;
          if (good_q) begin
            lock_q <= 1'b1;
            mode_q <= MODE_BANG;
          end
        end else begin
          good_q <= 1'b0;
          lock_q <= 1'b0;
          mode_q <= MODE_FREQ;
        end
      end
    end
  end
endmodule

// File: rtl/freq_lock_detect.sv
`timescale 1ns/1ps
module freq_lock_detect
  import fld_pkg::*;
#(
  parameter int WIN_LOG2   = 14,
  parameter int TOL_NARROW = 8,
  parameter int TOL_WIDE   = 32
) (
  input  logic ref_clk_i,
  input  logic rec_clk_i,
  input  logic rst_ni,
  input  logic range_sel_i,
  input  logic rate_sel_i,
  output logic lock_o,
  output logic mode_o
);
  localparam int CW = WIN_LOG2 + 3;

  logic [CW-1:0]       rec_cnt;
  logic [WIN_LOG2-1:0] win_timer;
  logic                win_tick, sel_chg, range_q, eval_valid, eval_ok;
  loop_mode_e          mode_s;

  fld_gray_xfer #(.CW(CW)) u_xfer (
    .rec_clk_i (rec_clk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .cnt_o     (rec_cnt)
  );

  fld_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk_i       (ref_clk_i),
    .rst_ni      (rst_ni),
    .range_sel_i (range_sel_i),
    .rate_sel_i  (rate_sel_i),
    .tick_o      (win_tick),
    .restart_o   (sel_chg),
    .range_o     (range_q),
    .timer_o     (win_timer)
  );

  fld_lock_fsm #(
    .CW         (CW),
    .WIN_LOG2   (WIN_LOG2),
    .TOL_NARROW (TOL_NARROW),
    .TOL_WIDE   (TOL_WIDE)
  ) u_fsm (
    .clk_i        (ref_clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (win_tick),
    .restart_i    (sel_chg),
    .range_i      (range_q),
    .cnt_i        (rec_cnt),
    .lock_o       (lock_o),
    .mode_o       (mode_s),
    .eval_valid_o (eval_valid),
    .eval_ok_o    (eval_ok)
  );

  assign mode_o = mode_s;
endmodule

// File: rtl/freq_lock_detect_chk.sv
`timescale 1ns/1ps
module freq_lock_detect_chk #(
  parameter int WIN_LOG2 = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                lock_i,
  input logic                mode_i,
  input logic                win_tick_i,
  input logic                eval_valid_i,
  input logic                eval_ok_i,
  input logic                sel_chg_i,
  input logic [WIN_LOG2-1:0] timer_i
);
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> $past(win_tick_i)); // R7
  AST_MODE_TRACKS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == lock_i); // R7
  AST_LOCK_RISE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> $past(eval_valid_i && eval_ok_i)); // R6
  AST_LOCK_FALL_OUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_i) |-> $past(eval_valid_i && !eval_ok_i)); // R5
  AST_BAD_WINDOW_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_valid_i && !eval_ok_i) |=> !lock_i); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg_i |=> (timer_i == '0) && !eval_valid_i); // R8
endmodule

bind freq_lock_detect freq_lock_detect_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .clk_i        (ref_clk_i),
  .rst_ni       (rst_ni),
  .lock_i       (lock_o),
  .mode_i       (mode_o),
  .win_tick_i   (win_tick),
  .eval_valid_i (eval_valid),
  .eval_ok_i    (eval_ok),
  .sel_chg_i    (sel_chg),
  .timer_i      (win_timer)
);

// File: tb/sim_freq_lock_detect.sv
`timescale 1ns/1ps
module sim_freq_lock_detect;
  localparam int WL   = 10;
  localparam int TN   = 8;
  localparam int TWD  = 32;
  localparam int EXPC = 1 << WL;

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic range_sel = 1'b0, rate_sel = 1'b0;
  logic lock, mode;
  real  rec_half = 5.0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  freq_lock_detect #(.WIN_LOG2(WL), .TOL_NARROW(TN), .TOL_WIDE(TWD)) u0 (
    .ref_clk_i (ref_clk),
    .rec_clk_i (rec_clk),
    .rst_ni    (rst_n),
    .range_sel_i (range_sel),
    .rate_sel_i  (rate_sel),
    .lock_o    (lock),
    .mode_o    (mode)
  );

  always #5 ref_clk = ~ref_clk;
  initial begin
    #3;
    forever #(rec_half) rec_clk = ~rec_clk;
  end

  function automatic int win_len(bit rate);
    return rate ? EXPC / 4 : EXPC;
  endfunction

  function automatic bit exp_lock(int d, bit wide);
    int a;
    a = (d < 0) ? -d : d;
    return a <= (wide ? TWD : TN);
  endfunction

  function automatic bit near_edge(int d);
    int a;
    a = (d < 0) ? -d : d;
    return (a >= TN - 3 && a <= TN + 3) || (a >= TWD - 3 && a <= TWD + 3);
  endfunction

  task automatic set_dev(int d, bit rate);
    rec_half = (10.0 * win_len(rate)) / (EXPC + d) / 2.0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, bit exp);
    chk(req, "lock_o", lock, exp);
    chk(req, "mode_o", mode, exp);
  endtask

  task automatic apply(string req, int d, bit wide, bit rate);
    range_sel = wide;
    rate_sel  = rate;
    set_dev(d, rate);
    wait_cyc(5 * win_len(rate));
    chk_out(req, exp_lock(d, wide));
  endtask

  initial begin
    wait_cyc(190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1a2b));
    // R1: held in reset
    set_dev(0, 1'b0);
    wait_cyc(20);
    chk_out("R1", 1'b0);
    rst_n = 1'b1;
    // R6: prime window, then two good windows -> lock near 3 windows after release
    wait_cyc(EXPC * 5 / 2);
    chk_out("R6", 1'b0);
    wait_cyc(EXPC);
    chk_out("R6", 1'b1);
    // R5: out-of-range from mid-window; the boundary at 4 windows clears lock
    set_dev(60, 1'b0);
    wait_cyc(EXPC);
    chk_out("R5", 1'b0);
    // R3 / R4: tolerance selects
    apply("R4", 20, 1'b1, 1'b0);
    apply("R3", 20, 1'b0, 1'b0);
    apply("R4", -20, 1'b1, 1'b0);
    apply("R3", 4, 1'b0, 1'b0);
    apply("R4", -60, 1'b1, 1'b0);
    // R2: quarter-rate reference
    apply("R2", 0, 1'b0, 1'b1);
    apply("R2", 60, 1'b1, 1'b1);
    apply("R2", -20, 1'b1, 1'b1);
    rate_sel = 1'b1;
    range_sel = 1'b1;
    rec_half = 5.0; // word-rate clock against quarter-rate window
    wait_cyc(5 * EXPC / 4);
    chk_out("R2", 1'b0);
    // R8: repeated select changes keep every window from completing
    apply("R8", 20, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      range_sel = 1'b0;
      wait_cyc(400);
      range_sel = 1'b1;
      wait_cyc(400);
    end
    range_sel = 1'b0;
    wait_cyc(400);
    chk_out("R8", 1'b1);
    wait_cyc(EXPC);
    chk_out("R8", 1'b0);
    // R1: reset while locked clears outputs immediately
    apply("R3", 0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk_out("R1", 1'b0);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk_out("R1", 1'b0);
    // R7: mode follows lock through random scenarios
    for (int k = 0; k < 8; k++) begin
      int d;
      bit w, r;
      do d = int'($urandom_range(140)) - 70; while (near_edge(d));
      w = 1'($urandom_range(1));
      r = 1'($urandom_range(1));
      apply(w ? "R7 R4" : "R7 R3", d, w, r);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule